// File: doc/BRIEF.md
# Front-End Packet Tagger with Zero Suppression

This block sits between a front-end link and a downstream processor. The link sends packets of 20-bit words. Two strobes qualify each word. A control strobe marks the opening and closing handshake words. A data strobe marks each payload word. The block turns every payload word into a 32-bit word. The upper 12 bits carry a tag worked out from the word's position in the packet: a class bit, a 7-bit index field and a 4-bit sequence field. The low 20 bits keep the original content. When the closing handshake arrives, the block appends one trailer word that carries two checking flags.

A packet body holds 970 payload words, in this order:
- 5 header words.
- 960 data words: 80 counts of 12 words each.
- 4 user words.
- 1 parity word.

A mode input can switch on zero suppression. In that mode, data words whose 20 bits are all zero are dropped. Every other word is always forwarded. Tagged words pass through a small elastic buffer to a valid/ready output. The output can therefore stall briefly while input keeps arriving at up to one word per cycle.

Top module: `fe_packet_tagger`

## Requirements
- R1: Payload words 0 to 4 of a packet are output as bit 31 = 1, bits 30-24 = 0, bits 23-20 = the word's position (0 to 4), bits 19-0 = the input word.
- R2: Payload words 5 to 964 are output as bit 31 = 0, with bits 30-24 = (p-5)/12 and bits 23-20 = (p-5)%12, where p is the position. Bits 30-24 therefore run 0 to 79 and bits 23-20 run 0 to 11. Bits 19-0 are the input word.
- R3: Payload words 965 to 969 (four user words, then the parity word) are output as bit 31 = 1, bits 30-24 = 1, bits 23-20 = p-965, bits 19-0 = the input word.
- R4: The closing handshake produces exactly one trailer word, output after all words of the packet. Its bits 31-20 are 0xFFF and its bits 19-2 are zero.
- R5: With suppression off, a complete packet yields exactly 971 output words.
- R6: With suppression on, data words whose 20 bits are all zero are not output. Header, user and parity words are output even when they are zero.
- R7: A suppressed word still moves the count and sequence fields forward, so the words after it keep their positional tags.
- R8: Trailer bit 0 is 1 exactly when the XOR of all received payload words, including the parity word, is nonzero.
- R9: Trailer bit 1 is 1 exactly when the number of payload words between the two handshakes is not 970.
- R10: Handshake words are not output. A data-strobe word that arrives outside a packet is ignored.
- R11: While out_valid is high and out_ready is low, out_data holds steady. No word is lost or reordered when the output stalls.
- R12: During and right after reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 20 | Incoming link word |
| in_cav | input | 1 | Control strobe: opening or closing handshake word |
| in_dav | input | 1 | Data strobe: payload word |
| suppress_en | input | 1 | Drop all-zero data words when high |
| out_data | output | 32 | Tagged output word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Downstream accepts the word this cycle |

## Verification
The tags come from a running position counter. If that counter slips by even one word, the class, count or sequence field of the very next output word is wrong, and the error lasts until the packet ends. Any counter error therefore shows in the first word that leaves the buffer after it, typically one or two cycles later. A wrong parity or length accumulator shows only in the trailer flags, one cycle after the closing handshake. A fault in the buffer shows as a missing, repeated or shifted word during a stall. The scoreboard compares every output word and every packet length against an expected stream built from the requirements alone.

// File: rtl/fetag_pkg.sv
// Shared packet geometry and types for the front-end packet tagger.
package fetag_pkg;
    localparam int HDR_WORDS  = 5;
    localparam int CHANNELS   = 80;
    localparam int SEQ_PER_CH = 12;
    localparam int TAIL_WORDS = 5;
    localparam int DATA_WORDS = CHANNELS * SEQ_PER_CH;
    localparam int BODY_WORDS = HDR_WORDS + DATA_WORDS + TAIL_WORDS;
    localparam int POS_W      = $clog2(BODY_WORDS + 1);

    typedef enum logic [1:0] {
        CLS_HDR  = 2'd0,
        CLS_DATA = 2'd1,
        CLS_TAIL = 2'd2
    } word_cls_e;

    localparam logic [6:0] IDX_TAIL    = 7'd1;
    localparam logic [6:0] IDX_TRAILER = 7'h7F;
    localparam logic [3:0] SEQ_TRAILER = 4'hF;
endpackage

// File: rtl/fetag_tagger.sv
// Tags each payload word by its position in the packet and emits the trailer.
// Assumes at most one strobe per cycle. Handshakes open and close a packet.
// Payload words beyond the expected body length are dropped and flagged.
module fetag_tagger
    import fetag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] in_word,
    input  logic        in_cav,
    input  logic        in_dav,
    input  logic        suppress_en,
    output logic        push,
    output logic [31:0] push_word
);
    localparam logic [POS_W-1:0] HDR_END  = POS_W'(HDR_WORDS);
    localparam logic [POS_W-1:0] DATA_END = POS_W'(HDR_WORDS + DATA_WORDS);
    localparam logic [POS_W-1:0] BODY_END = POS_W'(BODY_WORDS);
    localparam logic [3:0]       SQ_LAST  = 4'(SEQ_PER_CH - 1);

    logic             in_pkt;
    logic [POS_W-1:0] pos;
    logic [6:0]       ch;
    logic [3:0]       sq;
    logic [19:0]      par;
    logic             extra;
    word_cls_e        cls;
    logic [POS_W-1:0] toff;

    // Classify the current position into header, data or tail region.
    always_comb begin
        toff = pos - DATA_END;
        if (pos < HDR_END)       cls = CLS_HDR;
        else if (pos < DATA_END) cls = CLS_DATA;
        else                     cls = CLS_TAIL;
    end

    // Track packet framing, position, parity and build the tagged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt    <= 1'b0;
            pos       <= '0;
            ch        <= '0;
            sq        <= '0;
            par       <= '0;
            extra     <= 1'b0;
            push      <= 1'b0;
            push_word <= '0;
        end else begin
            push <= 1'b0;
            if (in_cav && !in_pkt) begin
                in_pkt <= 1'b1;
                pos    <= '0;
                ch     <= '0;
                sq     <= '0;
                par    <= '0;
                extra  <= 1'b0;
            end else if (in_cav && in_pkt) begin
                in_pkt    <= 1'b0;
                push      <= 1'b1;
                push_word <= {1'b1, IDX_TRAILER, SEQ_TRAILER, 18'd0,
                              (pos != BODY_END) || extra, par != 20'd0};
            end else if (in_dav && in_pkt) begin
                par <= par ^ in_word;
                if (pos == BODY_END) begin
                    extra <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                    case (cls)
                        CLS_HDR: begin
                            push      <= 1'b1;
                            push_word <= {1'b1, 7'd0, pos[3:0], in_word};
                        end
                        CLS_DATA: begin
                            push      <= !(suppress_en && in_word == 20'd0);
                            push_word <= {1'b0, ch, sq, in_word};
                            if (sq == SQ_LAST) begin
                                sq <= '0;
                                ch <= ch + 1'b1;
                            end else begin
                                sq <= sq + 1'b1;
                            end
                        end
                        default: begin
                            push      <= 1'b1;
                            push_word <= {1'b1, IDX_TAIL, toff[3:0], in_word};
                        end
                    endcase
                end
            end
        end
    end

    AST_HDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_word[31] && push_word[30:24] == 7'd0 |-> push_word[23:20] < 4'(HDR_WORDS)); // R1
    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        push && !push_word[31] |-> push_word[30:24] < 7'(CHANNELS) && push_word[23:20] <= SQ_LAST); // R2
    AST_TAIL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_word[31] && push_word[30:24] == IDX_TAIL |-> push_word[23:20] < 4'(TAIL_WORDS)); // R3
    AST_TRAILER_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_word[30:24] == IDX_TRAILER |-> push_word[31] && push_word[19:2] == 18'd0); // R4
    AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push && !push_word[31] && $past(suppress_en) |-> push_word[19:0] != 20'd0); // R6
endmodule

// File: rtl/fetag_fifo.sv
// Small elastic buffer between the tagger and the valid/ready output.
// Assumes DEPTH is a power of two and the writer never overfills it.
module fetag_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          rd_en;
    logic          full;

    // Derive handshake status from the occupancy count.
    always_comb begin
        rd_valid = cnt != '0;
        full     = cnt == (AW + 1)'(DEPTH);
        rd_en    = rd_valid && rd_ready;
        rd_data  = mem[rp];
    end

    // Store incoming words.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            cnt <= cnt + (AW + 1)'(wr_en) - (AW + 1)'(rd_en);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full || rd_en); // R11
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R11
endmodule

// File: rtl/fe_packet_tagger.sv
// Top level: tags front-end payload words and buffers them for a
// valid/ready consumer. Input arrives at most one word per cycle; stalls
// must stay shorter than the buffer can absorb.
module fe_packet_tagger #(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] in_word,
    input  logic        in_cav,
    input  logic        in_dav,
    input  logic        suppress_en,
    output logic [31:0] out_data,
    output logic        out_valid,
    input  logic        out_ready
);
    logic        push;
    logic [31:0] push_word;

    fetag_tagger u_tagger (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_word    (in_word),
        .in_cav     (in_cav),
        .in_dav     (in_dav),
        .suppress_en(suppress_en),
        .push       (push),
        .push_word  (push_word)
    );

    fetag_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (push_word),
        .rd_valid(out_valid),
        .rd_ready(out_ready),
        .rd_data (out_data)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R12
endmodule

// File: tb/tb_fe_packet_tagger.sv
module tb_fe_packet_tagger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] in_word = '0;
    logic        in_cav = 1'b0;
    logic        in_dav = 1'b0;
    logic        suppress_en = 1'b0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int checks = 0;
    int fails = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    int rx_len = 0;

    logic [31:0] exp_q[$];
    int          len_q[$];

    always #5 clk = ~clk;

    fe_packet_tagger dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_cav(in_cav),
        .in_dav(in_dav), .suppress_en(suppress_en), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    // Backpressure pattern (R11): low one cycle in four while enabled.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= bp_mode ? (cyc % 4 != 0) : 1'b1;
    end

    // Monitor: compare each accepted word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected word actual=%h expected=none", out_data);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (out_data !== e) begin
                    fails++;
                    $display("FAIL R1-R9 word mismatch actual=%h expected=%h", out_data, e);
                end
            end
            rx_len++;
            if (out_data[31:20] == 12'hFFF) begin
                int el;
                el = (len_q.size() != 0) ? len_q.pop_front() : -1;
                checks++;
                if (rx_len != el) begin
                    fails++;
                    $display("FAIL R5 packet length actual=%0d expected=%0d", rx_len, el);
                end
                rx_len = 0;
            end
        end
    end

    task automatic put(input bit c, input bit d, input logic [19:0] w);
        @(negedge clk);
        in_cav = c; in_dav = d; in_word = w;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put(1'b0, 1'b0, 20'd0);
    endtask

    function automatic logic [19:0] gen(input int i, input bit zeros);
        if (zeros && (i == 4 || i == 965)) return 20'd0;            // R6 non-data zeros kept
        if (zeros && i >= 5 && i < 965 && (i % 5 == 0)) return 20'd0; // R6/R7
        return 20'((i * 40503 + 7) & 20'hFFFFF) | 20'h1;
    endfunction

    // Driver: send one packet and push expected output words.
    task automatic send_pkt(input int nbody, input bit supp, input bit bad_par,
                            input bit zeros, input int gap);
        logic [19:0] par;
        logic [19:0] w;
        int n;
        par = '0;
        n = 0;
        suppress_en = supp;
        put(1'b1, 1'b0, 20'hFFFFF);
        for (int i = 0; i < nbody; i++) begin
            w = gen(i, zeros);
            if (i == 969) w = bad_par ? (par ^ 20'h1) : par;
            par = par ^ w;
            if (i < 5) begin
                exp_q.push_back({1'b1, 7'd0, 4'(i), w});                 // R1
                n++;
            end else if (i < 965) begin
                if (!(supp && w == 20'd0)) begin                          // R6, R7
                    exp_q.push_back({1'b0, 7'((i - 5) / 12), 4'((i - 5) % 12), w}); // R2
                    n++;
                end
            end else begin
                exp_q.push_back({1'b1, 7'd1, 4'(i - 965), w});           // R3
                n++;
            end
            put(1'b0, 1'b1, w);
            if (gap > 0) idle(gap);
        end
        put(1'b1, 1'b0, 20'd0);
        exp_q.push_back({12'hFFF, 18'd0, nbody != 970, par != 20'd0});    // R4, R8, R9
        len_q.push_back(n + 1);
        put(1'b0, 1'b0, 20'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12 out_valid in reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12 out_valid after reset actual=%b expected=0", out_valid);
        end
        put(1'b0, 1'b1, 20'h12345);   // R10: stray word outside a packet
        idle(3);
        send_pkt(970, 1'b0, 1'b0, 1'b0, 0);  // R1-R5 plain
        idle(5);
        send_pkt(970, 1'b0, 1'b0, 1'b1, 0);  // R6: zeros kept with suppression off
        idle(5);
        send_pkt(970, 1'b1, 1'b0, 1'b1, 0);  // R6, R7 suppression
        idle(5);
        send_pkt(970, 1'b0, 1'b1, 1'b0, 0);  // R8 parity error
        idle(5);
        send_pkt(600, 1'b0, 1'b0, 1'b0, 0);  // R9 short packet
        idle(5);
        bp_mode = 1'b1;
        send_pkt(970, 1'b1, 1'b0, 1'b1, 1);  // R11 backpressure
        idle(40);
        bp_mode = 1'b0;
        idle(20);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11 words missing actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule